// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block sits behind a deserializer and receives a 10-bit word every clock. The word boundary is arbitrary. It holds the previous word and joins it to the current one, which gives a 20-bit window. It then tests all ten bit offsets of that window at the same time against two programmable comma patterns, called plus and minus. Each pattern has its own alignment enable. When an enabled comma appears at an offset other than the current boundary, the block adopts that offset and pulses a realign strobe. Once locked, it keeps the boundary until a comma turns up somewhere else.

Every word leaves through one output register, cut at the boundary in force. A comma strobe goes high for each output word that matches either pattern. Bit 0 of every word is the earliest bit in time. Only the low `MATCH_BITS` bits of a candidate are compared. By default these are bits 6:0, which holds the seven-bit comma signature.

Top module: `comma_aligner`

## Requirements
- R1: While reset is held, and on leaving it, `word_o` is zero and both strobes are low. The boundary starts at offset 0.
- R2: `comma_o` is high exactly when the word on `word_o` equals `plus_pat` or `minus_pat` on bits 6:0.
- R3: A comma found at the offset already in use leaves the boundary as it is and does not raise `realign_o`.
- R4: An enabled comma found at a new offset k (0 to 9, counted from bit 0 of the older word) moves the boundary to k. `realign_o` is high for one cycle, together with `comma_o`, on the output word that is that comma.
- R5: With only one enable set, a comma of the other pattern has no effect on the boundary or on `realign_o`.
- R6: With both enables low, words keep passing through at the current boundary and `realign_o` stays low.
- R7: When enabled commas match at more than one offset of the same window, the lowest offset is taken.
- R8: The word sampled on a clock edge completes a window. After that edge, `word_o` holds the 10 bits starting at the boundary offset of that window, where the window is the previous word's bits 0 to 9 followed by the current word's bits 0 to 9.
- R9: Bits 9:7 of a candidate have no effect on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| align_plus_en | input | 1 | Allow alignment on the plus pattern |
| align_minus_en | input | 1 | Allow alignment on the minus pattern |
| plus_pat | input | W | Plus comma pattern, bit 0 earliest |
| minus_pat | input | W | Minus comma pattern, bit 0 earliest |
| rx_word | input | W | Unaligned word from the deserializer |
| word_o | output | W | Word cut at the current boundary |
| comma_o | output | 1 | Output word matches a comma pattern |
| realign_o | output | 1 | Boundary moved on this output word |

## Verification
The assertions assume that a new word arrives on every clock. They also assume that the patterns and enables only change between runs, because the comma check compares the output with the patterns of the previous cycle. The stimulus keeps to both assumptions: it drives one word per cycle from a bit stream and sets the patterns and enables before releasing reset. The filler between commas alternates 0 and 1, so it never holds five equal bits in a row. As a result, every match in the stream comes from a comma the bench placed on purpose, and the expected boundary follows from where the bench put it.

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int W          = 10,
  parameter int MATCH_BITS = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         align_plus_en,
  input  logic         align_minus_en,
  input  logic [W-1:0] plus_pat,
  input  logic [W-1:0] minus_pat,
  input  logic [W-1:0] rx_word,
  output logic [W-1:0] word_o,
  output logic         comma_o,
  output logic         realign_o
);
  localparam int OW = $clog2(W);
  localparam logic [W-1:0] MASK = W'((1 << MATCH_BITS) - 1);

  logic [W-1:0]   prev_q;
  logic [OW-1:0]  off_q, off_nxt;
  logic [2*W-1:0] win;
  logic [W-1:0]   hit_p, hit_m, hit_en, nxt_word;
  logic           found;

  assign win = {rx_word, prev_q};

  for (genvar k = 0; k < W; k++) begin : g_off
    wire [W-1:0] cand = win[k +: W];
    assign hit_p[k] = ((cand ^ plus_pat)  & MASK) == '0;
    assign hit_m[k] = ((cand ^ minus_pat) & MASK) == '0;
  end

  assign hit_en = (align_plus_en ? hit_p : '0) | (align_minus_en ? hit_m : '0);

  always_comb begin
    found   = 1'b0;
    off_nxt = off_q;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_en[k]) begin
        found   = 1'b1;
        off_nxt = OW'(k);
      end
    end
  end

  assign nxt_word = win[off_nxt +: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      off_q     <= '0;
      word_o    <= '0;
      comma_o   <= 1'b0;
      realign_o <= 1'b0;
    end else begin
      prev_q    <= rx_word;
      off_q     <= off_nxt;
      word_o    <= nxt_word;
      comma_o   <= (((nxt_word ^ plus_pat) & MASK) == '0) ||
                   (((nxt_word ^ minus_pat) & MASK) == '0);
      realign_o <= found && (off_nxt != off_q);
    end
  end

  AST_REALIGN_HAS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    realign_o |-> comma_o); // R4
  AST_REALIGN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    realign_o |-> off_q != $past(off_q)); // R4
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < OW'(W)); // R4
  AST_HOLD_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !realign_o |-> off_q == $past(off_q)); // R3
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!align_plus_en && !align_minus_en) |=> !realign_o); // R6
  AST_COMMA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    comma_o |-> ((((word_o ^ $past(plus_pat)) & MASK) == '0) ||
                 (((word_o ^ $past(minus_pat)) & MASK) == '0))); // R2
endmodule

// File: tb/sim_comma_aligner.sv
`timescale 1ns/1ps
module sim_comma_aligner;
  localparam logic [9:0] PLUS  = 10'h17C;
  localparam logic [9:0] MINUS = 10'h283;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ep = 1'b0, em = 1'b0;
  logic [9:0] rx_word = '0;
  logic [9:0] word_o;
  logic comma_o, realign_o;
  int checks = 0, errors = 0;
  bit done = 0;
  bit sb [0:255];

  always #4 clk = ~clk;

  comma_aligner u0 (.clk(clk), .rst_n(rst_n), .align_plus_en(ep), .align_minus_en(em),
    .plus_pat(PLUS), .minus_pat(MINUS), .rx_word(rx_word),
    .word_o(word_o), .comma_o(comma_o), .realign_o(realign_o));

  function automatic bit gb(int i);
    return (i < 0) ? 1'b0 : sb[i];
  endfunction

  function automatic logic [9:0] slice(int s);
    logic [9:0] v;
    for (int b = 0; b < 10; b++) v[b] = gb(s + b);
    return v;
  endfunction

  function automatic bit mt(logic [9:0] v, logic [9:0] p);
    return ((v ^ p) & 10'h07F) == 10'h000;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) sb[i] = i[0];
  endtask

  task automatic put(int p, bit neg);
    for (int b = 0; b < 10; b++) sb[p + b] = neg ? MINUS[b] : PLUS[b];
  endtask

  task automatic run(bit pe, bit me, int nwords, string tag);
    int bnd = 0;
    ep = pe; em = me; rx_word = '0; rst_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(word_o == 10'h000, "R1", "reset word", word_o, 0);
    chk(!comma_o && !realign_o, "R1", "reset strobes", {comma_o, realign_o}, 0);
    rst_n = 1'b1;
    for (int j = 0; j < nwords; j++) begin
      int base, kk;
      bit found, erl, ec;
      logic [9:0] ew;
      rx_word = slice(10 * j);
      @(posedge clk); #1;
      base = 10 * (j - 1);
      found = 0; kk = 0;
      for (int k = 9; k >= 0; k--) begin
        logic [9:0] v;
        v = slice(base + k);
        if ((pe && mt(v, PLUS)) || (me && mt(v, MINUS))) begin found = 1; kk = k; end
      end
      erl = found && (kk != bnd);
      if (found) bnd = kk;
      ew = slice(base + bnd);
      ec = mt(ew, PLUS) || mt(ew, MINUS);
      chk(word_o == ew, {tag, " R8"}, "word", word_o, ew);
      chk(comma_o == ec, {tag, " R2"}, "comma", comma_o, ec);
      chk(realign_o == erl, tag, "realign", realign_o, erl);
    end
  endtask

  initial begin
    for (int m = 0; m < 2; m++)
      for (int off = 0; off < 10; off++) begin
        fill(); put(30 + off, m[0]); run(1, 1, 8, (off == 0) ? "R3" : "R4");
      end
    fill(); put(33, 0); put(63, 0); run(1, 1, 9, "R3");
    fill(); put(35, 0); put(55, 1); run(1, 1, 9, "R3");
    fill(); put(33, 0); put(66, 1); run(1, 1, 9, "R4");
    fill(); put(34, 1); run(1, 0, 8, "R5");
    fill(); put(36, 0); run(0, 1, 8, "R5");
    fill(); put(34, 0); put(57, 1); run(0, 0, 9, "R6");
    fill(); put(32, 0); put(39, 0); run(1, 1, 8, "R7");
    fill(); put(32, 1); put(39, 0); run(1, 0, 8, "R7");
    fill(); put(32, 1); put(39, 0); run(1, 1, 8, "R7");
    fill(); put(37, 0); sb[44] = 1; sb[45] = 0; sb[46] = 1; run(1, 1, 8, "R9");
    fill(); put(41, 1); sb[48] = 0; sb[49] = 1; sb[50] = 0; run(1, 1, 8, "R9");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule